// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline. It looks at the two source register numbers of the instruction now executing. It compares them with the destination numbers and write enables of the two instructions ahead of it: the one in the memory stage and the one in write-back. It then picks, for each ALU operand, where the value should come from. The choices are the value read from the register file, the newer ALU result held after execute, or the older result held after memory.

The two select codes and the two selected operand values come out of the same purely combinational path. An operand that depends on the instruction one or two slots ahead therefore reaches the ALU without a stall. No write-back-to-decode path is needed, because the register file returns a same-cycle write to a reader in decode. Stalling for loads and bypassing of store data are handled elsewhere.

Top module: `alu_fwd_unit`

## Requirements
- R1: Each select output uses the code 2'b00 for the register-file value, 2'b10 for the memory-stage result and 2'b01 for the write-back result; the code 2'b11 is never produced.
- R2: An operand selects the memory-stage result when the memory-stage write enable is set, its destination is nonzero, and that destination equals the operand's source number (source A for operand A, source B for operand B).
- R3: An operand selects the write-back result when the write-back write enable is set, its destination is nonzero, it equals the source number, and the memory-stage path is not selected for that operand; a memory-stage instruction with the same destination but its write enable clear does not block it.
- R4: When both later stages write the register an operand reads, the memory-stage (more recent) result is selected.
- R5: A destination of register 0 is never forwarded from either stage, even when the source number is also 0; the operand then takes the register-file value.
- R6: A stage whose write enable is clear is never forwarded from, whatever its destination number.
- R7: The A and B selects are decided independently, so both operands may be forwarded in the same cycle from the same stage or from different stages.
- R8: Each operand output equals the value named by its select code: register-file value for 2'b00, memory-stage result for 2'b10, write-back result for 2'b01.
- R9: Selects and operands have no register in their path; a change on any input shows on the outputs in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the executing instruction |
| ex_src_b | input | 5 | Second source register number of the executing instruction |
| ex_val_a | input | 32 | Register-file value read for source A |
| ex_val_b | input | 32 | Register-file value read for source B |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register number |
| mem_res | input | 32 | ALU result held in the memory stage |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_dst | input | 5 | Write-back destination register number |
| wb_res | input | 32 | Result held in the write-back stage |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | 32 | Operand A to the ALU |
| opnd_b | output | 32 | Operand B to the ALU |

## Verification
The bench goes after the double-writer case, where a design without the nearer-wins rule would hand the ALU the stale write-back value. It drives destination register 0 with the write enable set, which a design missing the zero test would forward as a live value. It also drives matching destinations with the enable clear, which a careless design would either forward or, for the memory stage, let wrongly block a valid write-back bypass. It mixes cases where A and B take different or identical sources, which would expose a design that coupled the two selects or swapped the mux inputs behind the 2'b01 and 2'b10 codes.

// File: rtl/alu_fwd_pkg.sv
// Shared widths and the select encoding for the execute-stage bypass unit.
// Assumes 5-bit register numbers and 32-bit data by default.
package alu_fwd_pkg;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int N_OPND = 2;

    // Select code; the bit positions are decoded by the operand mux.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
// Decides the bypass source for one ALU operand.
// Assumes destination register 0 is hard-wired to zero and never forwarded.
// Purely combinational; the nearer (memory-stage) producer wins.
module fwd_select
    import alu_fwd_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] src,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_dst,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_dst,
    output fwd_sel_e      sel
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic hit_mem;
    logic hit_wb;

    // Match the source against each later stage's live destination.
    always_comb begin
        hit_mem = mem_we && (mem_dst != ZERO_REG) && (mem_dst == src);
        hit_wb  = wb_we  && (wb_dst  != ZERO_REG) && (wb_dst  == src);
    end

    // Pick the source, nearer stage first.
    always_comb begin
        if (hit_mem)     sel = SEL_MEM;
        else if (hit_wb) sel = SEL_WB;
        else             sel = SEL_RF;
    end

    // Guard the produced code against the inputs.
    always_comb begin
        p_sel_legal_r1: assert (sel != 2'b11);
        p_wb_needs_en_r6: assert (!(sel == SEL_WB && !wb_we));
        p_mem_needs_en_r6: assert (!(sel == SEL_MEM && !mem_we));
        p_no_zero_mem_r5: assert (!(sel == SEL_MEM && mem_dst == ZERO_REG));
        p_no_zero_wb_r5: assert (!(sel == SEL_WB && wb_dst == ZERO_REG));
    end
endmodule

// File: rtl/fwd_opmux.sv
// Three-way operand multiplexer steered by a bypass select code.
// Assumes code 2'b11 never arrives; if it does, the register-file value is used.
module fwd_opmux
    import alu_fwd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  fwd_sel_e      sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] out
);
    // Route the chosen value to the ALU input.
    always_comb begin
        case (sel)
            SEL_MEM: out = mem_val;
            SEL_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/alu_fwd_unit.sv
// Execute-stage operand bypass unit: one selector and one mux per ALU operand.
// Assumes the register file already handles same-cycle write-then-read, so
// only the memory-stage and write-back-stage results are bypassed here.
module alu_fwd_unit
    import alu_fwd_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = DATA_W
) (
    input  logic [RW-1:0] ex_src_a,
    input  logic [RW-1:0] ex_src_b,
    input  logic [DW-1:0] ex_val_a,
    input  logic [DW-1:0] ex_val_b,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_dst,
    input  logic [DW-1:0] mem_res,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_dst,
    input  logic [DW-1:0] wb_res,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    logic [RW-1:0] src  [N_OPND];
    logic [DW-1:0] rfv  [N_OPND];
    logic [DW-1:0] opnd [N_OPND];
    fwd_sel_e      sel  [N_OPND];

    // Gather the per-operand inputs into arrays.
    always_comb begin
        src[0] = ex_src_a;
        src[1] = ex_src_b;
        rfv[0] = ex_val_a;
        rfv[1] = ex_val_b;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fwd_select #(.RW(RW)) u_sel (
            .src     (src[g]),
            .mem_we  (mem_we),
            .mem_dst (mem_dst),
            .wb_we   (wb_we),
            .wb_dst  (wb_dst),
            .sel     (sel[g])
        );

        fwd_opmux #(.DW(DW)) u_mux (
            .sel     (sel[g]),
            .rf_val  (rfv[g]),
            .mem_val (mem_res),
            .wb_val  (wb_res),
            .out     (opnd[g])
        );

        // Cross-check selector and mux against the top-level inputs.
        always_comb begin
            p_near_wins_r4: assert (!(mem_we && mem_dst != '0 && mem_dst == src[g])
                                    || sel[g] == SEL_MEM);
            p_mux_wb_r8: assert (!(sel[g] == SEL_WB) || opnd[g] == wb_res);
            p_mux_mem_r8: assert (!(sel[g] == SEL_MEM) || opnd[g] == mem_res);
            p_mux_rf_r8: assert (!(sel[g] == SEL_RF) || opnd[g] == rfv[g]);
        end
    end

    // Drive the output ports.
    always_comb begin
        sel_a  = sel[0];
        sel_b  = sel[1];
        opnd_a = opnd[0];
        opnd_b = opnd[1];
    end
endmodule

// File: tb/alu_fwd_unit_bench.sv
module alu_fwd_unit_bench;
    localparam int RW = 5;
    localparam int DW = 32;
    localparam logic [DW-1:0] VA = 32'hA0A0_0001;
    localparam logic [DW-1:0] VB = 32'hB0B0_0002;
    localparam logic [DW-1:0] VM = 32'hC0C0_0003;
    localparam logic [DW-1:0] VW = 32'hD0D0_0004;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [RW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic [DW-1:0] ex_val_a, ex_val_b, mem_res, wb_res;
    logic          mem_we, wb_we;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    alu_fwd_unit u_alu_fwd_unit (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_val_a(ex_val_a), .ex_val_b(ex_val_b),
        .mem_we(mem_we), .mem_dst(mem_dst), .mem_res(mem_res),
        .wb_we(wb_we), .wb_dst(wb_dst), .wb_res(wb_res),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Vector: src_a, src_b, mem_we, mem_dst, wb_we, wb_dst, exp sel_a, exp sel_b, req id
    typedef struct packed {
        logic [4:0] sa;
        logic [4:0] sb;
        logic       mwe;
        logic [4:0] md;
        logic       wwe;
        logic [4:0] wd;
        logic [1:0] ea;
        logic [1:0] eb;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  5'd4, 1'b0, 5'd3,  1'b0, 5'd4, 2'b00, 2'b00, 4'd1}, // R1 nothing live
        '{5'd3,  5'd4, 1'b1, 5'd3,  1'b0, 5'd0, 2'b10, 2'b00, 4'd2}, // R2 back-to-back on A
        '{5'd3,  5'd4, 1'b1, 5'd4,  1'b0, 5'd0, 2'b00, 2'b10, 4'd2}, // R2 back-to-back on B
        '{5'd3,  5'd4, 1'b0, 5'd0,  1'b1, 5'd3, 2'b01, 2'b00, 4'd3}, // R3 second-previous on A
        '{5'd3,  5'd4, 1'b0, 5'd0,  1'b1, 5'd4, 2'b00, 2'b01, 4'd3}, // R3 second-previous on B
        '{5'd3,  5'd4, 1'b1, 5'd3,  1'b1, 5'd3, 2'b10, 2'b00, 4'd4}, // R4 double writer A
        '{5'd3,  5'd4, 1'b1, 5'd4,  1'b1, 5'd4, 2'b00, 2'b10, 4'd4}, // R4 double writer B
        '{5'd3,  5'd4, 1'b0, 5'd3,  1'b1, 5'd3, 2'b01, 2'b00, 4'd3}, // R3 disabled mem does not block
        '{5'd0,  5'd0, 1'b1, 5'd0,  1'b1, 5'd0, 2'b00, 2'b00, 4'd5}, // R5 zero everywhere
        '{5'd0,  5'd5, 1'b1, 5'd0,  1'b1, 5'd5, 2'b00, 2'b01, 4'd5}, // R5 zero on A only
        '{5'd3,  5'd4, 1'b0, 5'd3,  1'b0, 5'd9, 2'b00, 2'b00, 4'd6}, // R6 mem disabled
        '{5'd3,  5'd4, 1'b0, 5'd9,  1'b0, 5'd3, 2'b00, 2'b00, 4'd6}, // R6 wb disabled
        '{5'd7,  5'd7, 1'b1, 5'd7,  1'b0, 5'd0, 2'b10, 2'b10, 4'd7}, // R7 both from mem
        '{5'd7,  5'd9, 1'b1, 5'd7,  1'b1, 5'd9, 2'b10, 2'b01, 4'd7}, // R7 mixed stages
        '{5'd9,  5'd7, 1'b1, 5'd7,  1'b1, 5'd9, 2'b01, 2'b10, 4'd7}, // R7 mixed, swapped
        '{5'd6,  5'd6, 1'b0, 5'd6,  1'b1, 5'd6, 2'b01, 2'b01, 4'd7}, // R7 both from wb
        '{5'd31, 5'd1, 1'b1, 5'd31, 1'b1, 5'd1, 2'b10, 2'b01, 4'd2}, // R2 top register number
        '{5'd3,  5'd4, 1'b1, 5'd5,  1'b1, 5'd6, 2'b00, 2'b00, 4'd1}  // R1 no match
    };

    function automatic string tag(input logic [3:0] id);
        case (id)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
        case (s)
            2'b10:   return VM;
            2'b01:   return VW;
            default: return rf;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(posedge clk);
        #1;
        ex_src_a = v.sa; ex_src_b = v.sb;
        mem_we = v.mwe;  mem_dst = v.md;
        wb_we = v.wwe;   wb_dst = v.wd;
        @(negedge clk);
    endtask

    initial begin
        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
        mem_we = 1'b0; wb_we = 1'b0;
        ex_val_a = VA; ex_val_b = VB; mem_res = VM; wb_res = VW;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Quiet pipeline: register-file values pass through (R1, R8)
        check("R1", "idle sel_a", {30'd0, sel_a}, 32'd0);
        check("R1", "idle sel_b", {30'd0, sel_b}, 32'd0);
        check("R8", "idle opnd_a", opnd_a, VA);
        check("R8", "idle opnd_b", opnd_b, VB);
        rst_n = 1'b1;

        // Table walk: selects and operand values (R8 for the data)
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(tag(VECS[i].req), $sformatf("vec %0d sel_a", i), {30'd0, sel_a}, {30'd0, VECS[i].ea});
            check(tag(VECS[i].req), $sformatf("vec %0d sel_b", i), {30'd0, sel_b}, {30'd0, VECS[i].eb});
            check("R8", $sformatf("vec %0d opnd_a", i), opnd_a, pick(VECS[i].ea, VA));
            check("R8", $sformatf("vec %0d opnd_b", i), opnd_b, pick(VECS[i].eb, VB));
            check("R1", $sformatf("vec %0d code 11", i), {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
        end

        // R9: outputs follow a data change within the same cycle
        apply(VECS[13]);
        @(posedge clk);
        #1;
        mem_res = 32'h1234_5678;
        wb_res  = 32'h8765_4321;
        #0.5;
        check("R9", "opnd_a follows mem_res", opnd_a, 32'h1234_5678);
        check("R9", "opnd_b follows wb_res", opnd_b, 32'h8765_4321);
        // R9: a select change shows before the next edge
        mem_we = 1'b0;
        #0.5;
        check("R9", "sel_a drops with mem_we", {30'd0, sel_a}, 32'd0);
        check("R9", "opnd_a back to register file", opnd_a, VA);
        mem_res = VM; wb_res = VW;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule